// File: doc/BRIEF.md
# DMA Request Channel Mapper

This block sits between the request lines of on-chip peripherals and the request inputs of a 16-channel DMA engine. Each peripheral request line has its own mapping entry. The entry holds a valid bit and a 4-bit channel number. Software programs the entries through a simple write port and can read any entry back.

On every clock edge the block captures the peripheral request bus. If any captured bit is set, it looks up the channel for each active request. It then raises the request output of that channel one clock later. When several active requests name the same channel, they are OR-combined onto that channel's output. A request whose entry is not valid is dropped. Arbitration between channels, the transfer engines and the bus fabric belong to other blocks.

Top module: `dreq_chan_map`

## Requirements
- R1: While reset is high and on the first cycle after it, every `chan_req` bit is 0. Every mapping entry reads back with valid 0 and channel 0.
- R2: A write (`cfg_wr_en`=1 at a clock edge) stores `cfg_wr_valid` and the 4-bit `cfg_wr_chan` into entry `cfg_idx`. The read outputs `cfg_rd_valid` and `cfg_rd_chan` show entry `cfg_idx` without a clock edge.
- R3: A request bit set on `preq[i]` before clock edge k is captured at edge k. If entry i is valid with channel c, `chan_req[c]` is 1 after edge k+1.
- R4: Every channel number from 0 to 15 can be reached, including the lowest channel (0) and the highest channel (15).
- R5: An all-zero capture of `preq` gives `chan_req` equal to all zeros one edge later.
- R6: A request whose entry has valid 0 raises no channel output.
- R7: When two or more active requests map to the same channel, that channel's output is the OR of those requests. It is 1 if any of them is 1.
- R8: Active requests mapped to different channels raise all of those channels in the same cycle, and raise no other channel.
- R9: The bus is captured on every edge, so a request present for one edge raises its channel for exactly one cycle. A mapping write completed at an edge applies to the capture taken at that same edge.
- R10: Without a write, no mapping entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| preq | input | NUM_REQ | Peripheral request lines, one per source |
| cfg_wr_en | input | 1 | Mapping write strobe |
| cfg_idx | input | $clog2(NUM_REQ) | Entry index for writes and reads |
| cfg_wr_valid | input | 1 | Valid bit to store |
| cfg_wr_chan | input | 4 | Channel number to store |
| cfg_rd_valid | output | 1 | Stored valid bit of entry `cfg_idx` |
| cfg_rd_chan | output | 4 | Stored channel of entry `cfg_idx` |
| chan_req | output | 16 | Per-channel DMA request, registered |

## Verification
A corrupted mapping entry shows up on `cfg_rd_valid` and `cfg_rd_chan` as soon as that index is selected, with no clock needed. It also appears on `chan_req` two edges after the affected request line is raised, as a wrong channel, a missing channel or an extra channel. An error in the capture stage or the output register shows as a shifted latency or a stretched pulse. The bench compares every routed pattern against its own model of the entries, which catches such errors within three cycles of the stimulus.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    localparam int unsigned NUM_CH = 16;
    localparam int unsigned CH_W   = $clog2(NUM_CH);

    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [NUM_CH-1:0] chan_vec_t;

    typedef struct packed {
        logic  valid;
        chan_t chan;
    } map_entry_t;

    localparam map_entry_t MAP_RESET = '{valid: 1'b0, chan: '0};

    // One-hot channel vector for a single entry, gated by its request bit.
    function automatic chan_vec_t entry_hit(input map_entry_t e, input logic req);
        chan_vec_t v;
        v = '0;
        if (req && e.valid) begin
            v[e.chan] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/dreq_sampler.sv
module dreq_sampler #(
    parameter int unsigned NUM_REQ = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] preq_in,
    output logic [NUM_REQ-1:0] smp_q,
    output logic               smp_any
);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
        end else begin
            smp_q <= preq_in;
        end
    end

    assign smp_any = |smp_q;

endmodule

// File: rtl/dreq_map_regs.sv
module dreq_map_regs
    import dreq_pkg::*;
#(
    parameter int unsigned NUM_REQ = 32,
    localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  map_entry_t                   wr_entry,
    output map_entry_t [NUM_REQ-1:0]     map_q
);

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[g] <= MAP_RESET;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                map_q[g] <= wr_entry;
            end
        end
    end

endmodule

// File: rtl/dreq_router.sv
module dreq_router
    import dreq_pkg::*;
#(
    parameter int unsigned NUM_REQ = 32
) (
    input  logic [NUM_REQ-1:0]       smp,
    input  logic                     smp_any,
    input  map_entry_t [NUM_REQ-1:0] map_q,
    output chan_vec_t                route
);

    chan_vec_t hits [NUM_REQ+1];

    assign hits[0] = '0;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_src
        assign hits[r+1] = hits[r] | entry_hit(map_q[r], smp[r]);
    end

    // Lookup result is used only when the capture holds a set bit.
    assign route = smp_any ? hits[NUM_REQ] : '0;

endmodule

// File: rtl/dreq_chan_map.sv
module dreq_chan_map
    import dreq_pkg::*;
#(
    parameter int unsigned NUM_REQ = 32,
    localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] preq,
    input  logic               cfg_wr_en,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_wr_valid,
    input  logic [CH_W-1:0]    cfg_wr_chan,
    output logic               cfg_rd_valid,
    output logic [CH_W-1:0]    cfg_rd_chan,
    output logic [NUM_CH-1:0]  chan_req
);

    logic [NUM_REQ-1:0]       smp_q;
    logic                     smp_any;
    map_entry_t [NUM_REQ-1:0] map_q;
    map_entry_t               wr_entry;
    map_entry_t               rd_entry;
    chan_vec_t                route;

    assign wr_entry = '{valid: cfg_wr_valid, chan: cfg_wr_chan};

    dreq_sampler #(.NUM_REQ(NUM_REQ)) u_smp (
        .clk     (clk),
        .rst     (rst),
        .preq_in (preq),
        .smp_q   (smp_q),
        .smp_any (smp_any)
    );

    dreq_map_regs #(.NUM_REQ(NUM_REQ)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_idx   (cfg_idx),
        .wr_entry (wr_entry),
        .map_q    (map_q)
    );

    dreq_router #(.NUM_REQ(NUM_REQ)) u_route (
        .smp     (smp_q),
        .smp_any (smp_any),
        .map_q   (map_q),
        .route   (route)
    );

    always_comb begin
        rd_entry = MAP_RESET;
        if (int'(cfg_idx) < NUM_REQ) begin
            rd_entry = map_q[cfg_idx];
        end
    end

    assign cfg_rd_valid = rd_entry.valid;
    assign cfg_rd_chan  = rd_entry.chan;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_req <= '0;
        end else begin
            chan_req <= route;
        end
    end

endmodule

// File: rtl/dreq_chan_map_chk.sv
module dreq_chan_map_chk
    import dreq_pkg::*;
#(
    parameter int unsigned NUM_REQ = 32,
    localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cfg_wr_en,
    input logic [IDX_W-1:0]         cfg_idx,
    input logic                     cfg_wr_valid,
    input logic [CH_W-1:0]          cfg_wr_chan,
    input logic [NUM_REQ-1:0]       smp_q,
    input map_entry_t [NUM_REQ-1:0] map_q,
    input logic [NUM_CH-1:0]        chan_req
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (chan_req == '0));

    // R5
    idle_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(smp_q) == '0) |-> (chan_req == '0));

    // R2
    write_stores_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |=> (map_q[$past(cfg_idx)] == {$past(cfg_wr_valid), $past(cfg_wr_chan)}));

    // R10
    map_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr_en |=> $stable(map_q));

endmodule

bind dreq_chan_map dreq_chan_map_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_idx      (cfg_idx),
    .cfg_wr_valid (cfg_wr_valid),
    .cfg_wr_chan  (cfg_wr_chan),
    .smp_q        (smp_q),
    .map_q        (map_q),
    .chan_req     (chan_req)
);

// File: tb/dreq_chan_map_tb.sv
module dreq_chan_map_tb;

    localparam int NREQ = 32;
    localparam int IW   = 5;

    logic            clk = 1'b0;
    logic            rst;
    logic [NREQ-1:0] preq;
    logic            cfg_wr_en;
    logic [IW-1:0]   cfg_idx;
    logic            cfg_wr_valid;
    logic [3:0]      cfg_wr_chan;
    logic            cfg_rd_valid;
    logic [3:0]      cfg_rd_chan;
    logic [15:0]     chan_req;

    int checks   = 0;
    int failures = 0;

    logic       m_valid [NREQ];
    logic [3:0] m_chan  [NREQ];

    always #5 clk = ~clk;

    dreq_chan_map #(.NUM_REQ(NREQ)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .preq         (preq),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_idx      (cfg_idx),
        .cfg_wr_valid (cfg_wr_valid),
        .cfg_wr_chan  (cfg_wr_chan),
        .cfg_rd_valid (cfg_rd_valid),
        .cfg_rd_chan  (cfg_rd_chan),
        .chan_req     (chan_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [NREQ-1:0] v);
        logic [15:0] o = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (v[i] && m_valid[i]) o[m_chan[i]] = 1'b1;
        end
        return o;
    endfunction

    task automatic write_map(input int idx, input logic vld, input logic [3:0] ch);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_idx = IW'(idx); cfg_wr_valid = vld; cfg_wr_chan = ch;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_valid[idx] = vld; m_chan[idx] = ch;
    endtask

    // Raise a pattern for one capture, check the routed output two edges later.
    task automatic pulse(input string req, input logic [NREQ-1:0] v);
        @(negedge clk);
        preq = v;
        @(negedge clk);
        preq = '0;
        @(negedge clk);
        check(req, 32'(chan_req), 32'(model(v)));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 chan_req", 32'(chan_req), 32'h0);
        for (int i = 0; i < NREQ; i += 7) begin
            cfg_idx = IW'(i);
            #1;
            check("R1 rd", {27'h0, cfg_rd_valid, cfg_rd_chan}, 32'h0);
        end
        pulse("R1 unmapped after reset", 32'hFFFF_FFFF);
    endtask

    task automatic t_readback;
        write_map(3, 1'b1, 4'hA);
        write_map(30, 1'b0, 4'h5);
        cfg_idx = 5'd3; #1;
        check("R2 rd idx3", {27'h0, cfg_rd_valid, cfg_rd_chan}, 32'h1A);
        cfg_idx = 5'd30; #1;
        check("R2 rd idx30", {27'h0, cfg_rd_valid, cfg_rd_chan}, 32'h05);
    endtask

    task automatic t_single;
        write_map(0, 1'b1, 4'd0);
        write_map(31, 1'b1, 4'd15);
        write_map(7, 1'b1, 4'd9);
        pulse("R3 single idx7", 32'h0000_0080);
        check("R3 ch9", 32'(chan_req), 32'h0200);
        pulse("R4 lowest ch0", 32'h0000_0001);
        check("R4 ch0", 32'(chan_req), 32'h0001);
        pulse("R4 highest ch15", 32'h8000_0000);
        check("R4 ch15", 32'(chan_req), 32'h8000);
    endtask

    task automatic t_latency;
        @(negedge clk);
        preq = 32'h0000_0080;
        @(negedge clk);
        preq = '0;
        check("R3 not yet after capture", 32'(chan_req), 32'h0);
        @(negedge clk);
        check("R3 after second edge", 32'(chan_req), 32'h0200);
        @(negedge clk);
        check("R9 one cycle only", 32'(chan_req), 32'h0);
    endtask

    task automatic t_zero;
        pulse("R5 all zero", 32'h0);
        check("R5 zero out", 32'(chan_req), 32'h0);
    endtask

    task automatic t_invalid;
        write_map(12, 1'b0, 4'd4);
        pulse("R6 invalid idx12", 32'h0000_1000);
        check("R6 no channel", 32'(chan_req), 32'h0);
        pulse("R6 invalid idx30", 32'h4000_0000);
    endtask

    task automatic t_or;
        write_map(20, 1'b1, 4'd6);
        write_map(21, 1'b1, 4'd6);
        write_map(22, 1'b1, 4'd6);
        pulse("R7 both", 32'h0030_0000);
        check("R7 ch6", 32'(chan_req), 32'h0040);
        pulse("R7 one of three", 32'h0040_0000);
        check("R7 ch6 single", 32'(chan_req), 32'h0040);
    endtask

    task automatic t_multi;
        pulse("R8 spread", 32'h8010_0081);
        check("R8 exact", 32'(chan_req), 32'h8241);
        pulse("R8 with invalid", 32'hC000_1001);
        check("R8 exact2", 32'(chan_req), 32'h8001);
    endtask

    task automatic t_same_edge;
        @(negedge clk);
        preq = 32'h0000_0020;
        cfg_wr_en = 1'b1; cfg_idx = 5'd5; cfg_wr_valid = 1'b1; cfg_wr_chan = 4'd3;
        @(negedge clk);
        preq = '0; cfg_wr_en = 1'b0;
        m_valid[5] = 1'b1; m_chan[5] = 4'd3;
        @(negedge clk);
        check("R9 write same edge", 32'(chan_req), 32'h0008);
        @(negedge clk);
        check("R9 pulse ends", 32'(chan_req), 32'h0);
        // Remap: later samples follow the new entry.
        write_map(5, 1'b1, 4'd14);
        pulse("R9 remap", 32'h0000_0020);
        check("R9 ch14", 32'(chan_req), 32'h4000);
    endtask

    task automatic t_hold;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            preq = NREQ'(32'hA5A5_5A5A ^ (k * 32'h0101_0101));
        end
        @(negedge clk);
        preq = '0;
        for (int i = 0; i < NREQ; i++) begin
            cfg_idx = IW'(i);
            #1;
            check("R10 held", {27'h0, cfg_rd_valid, cfg_rd_chan}, {27'h0, m_valid[i], m_chan[i]});
        end
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREQ; i++) begin
            m_valid[i] = 1'b0; m_chan[i] = '0;
        end
        rst = 1'b1; preq = '0; cfg_wr_en = 1'b0; cfg_idx = '0;
        cfg_wr_valid = 1'b0; cfg_wr_chan = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_single();
        t_latency();
        t_zero();
        t_invalid();
        t_or();
        t_multi();
        t_same_edge();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule